// File: doc/BRIEF.md
# Bit-Test and Loop Branch Execution Unit

This unit executes the conditional-branch group of a small 8-bit processor once the operation has been decoded. Each operation names what it does (jump if a bit is set, jump if a bit is clear, jump if set and then clear the bit, or decrement and jump if the result is non-zero), where its operand lives, which bit to test, the current program counter and a signed 8-bit displacement. The unit reads the operand byte through a single-byte read/write port. It evaluates the condition, writes back a cleared bit or a decremented count when the operation calls for it, and returns the next program counter together with a taken flag.

Every operation keeps the unit busy for a fixed number of clock cycles. That number depends on the operation, on the operand kind and, for memory operands, on whether the access lands in internal high-speed RAM (input `fast_region`). The instruction length that is added to the program counter likewise depends on both operation and operand kind. Fetch, decode, address translation and interrupts live elsewhere: the port only presents the operand kind on `mem_sel`, and the surrounding datapath routes the access.

The controller is one state machine with these states. `ST_IDLE` waits for `start`. `ST_FETCH` issues the read. `ST_TEST` samples the returned byte and computes the result. `ST_STORE` issues the write when one is needed. `ST_HOLD` pads the remaining cycles. `ST_FINISH` is the one-cycle done state. Its transitions are: idle or finish to fetch on an accepted start of a legal pairing; idle or finish to hold on an accepted start of an illegal pairing; finish to idle without start; fetch to test; test to store; store to hold (or to finish once the count is spent); hold to hold while cycles remain; and hold to finish when the count reaches zero.

Top module: `cond_branch_unit`

## Requirements
- R1: On completion `next_pc` equals `pc_in` plus the instruction length, plus the displacement sign-extended to 16 bits when the branch is taken; the sum wraps modulo 65536.
- R2: With `op` = 0 (jump if set) the branch is taken when bit `bit_idx` of the operand byte is 1; with `op` = 1 (jump if clear) it is taken when that bit is 0; `taken` reports the outcome.
- R3: With `op` = 2 (jump if set, then clear) the branch is taken when the tested bit is 1, and the byte is written back with only that bit cleared; when the bit is 0 no write occurs, and ops 0 and 1 never write.
- R4: With `op` = 3 (decrement, jump if non-zero) the operand byte is written back as its value minus 1 modulo 256, and the branch is taken exactly when that result is non-zero.
- R5: Operand kinds on `src`: 0 accumulator bit, 1 flag-register bit, 2 short-direct bit, 3 special-register bit, 4 HL-indirect bit, 5 register B, 6 register C, 7 short-direct byte. Lengths: kinds 0 and 4 take 3 bytes; kind 3 takes 4; kinds 1 and 2 take 3 for op 0 and 4 for ops 1 and 2; op 3 takes 2 on kinds 5 and 6 and 3 on kind 7.
- R6: With `fast_region` = 1: kind 0 takes 8 cycles, kinds 4 and 2 take 10 (8 for kind 2 with op 0), and op 3 on kind 7 takes 8.
- R7: With `fast_region` = 0: kinds 4 and 2 take 11 cycles (9 for kind 2 with op 0); kind 3 takes 11; kind 1 takes 9 for op 0 and 11 for op 1; op 2 on kinds 1 to 4 takes 12; op 3 on kind 7 takes 10.
- R8: `fast_region` has no effect on kinds 0, 1, 3, 5 and 6: kind 0 always takes 8 cycles, kinds 1 and 3 always use the R7 counts, and op 3 on kinds 5 and 6 always takes 6.
- R9: An accepted `start` raises `busy` from the next cycle for exactly the cycle count; then `done` is high for one cycle with `busy` low, and `start` is ignored while `busy` is high.
- R10: A legal operation makes exactly one read, with `mem_rd` high in the first busy cycle and `mem_rdata` taken in the cycle that follows; any write is a single `mem_wr` pulse in the third busy cycle, and `mem_sel` carries the operand kind.
- R11: An illegal pairing (op 3 with kinds 0 to 4, or ops 0 to 2 with kinds 5 to 7) makes no access, is busy for 2 cycles, and completes with `taken` = 0 and `next_pc` = `pc_in`.
- R12: After reset `busy`, `done`, `taken`, `mem_rd` and `mem_wr` are 0 and `next_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse for a new operation |
| op | input | 2 | Operation code (R2 to R4) |
| src | input | 3 | Operand kind (R5) |
| bit_idx | input | 3 | Bit position tested or cleared |
| fast_region | input | 1 | 1 when the memory access hits internal high-speed RAM |
| pc_in | input | 16 | Program counter of the branch instruction |
| disp | input | 8 | Two's-complement branch displacement |
| busy | output | 1 | High while the operation is running |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch outcome of the last operation |
| next_pc | output | 16 | Next program counter of the last operation |
| mem_rd | output | 1 | Operand read strobe |
| mem_wr | output | 1 | Operand write strobe |
| mem_sel | output | 3 | Operand kind being accessed |
| mem_wdata | output | 8 | Byte written back |
| mem_rdata | input | 8 | Byte returned one cycle after `mem_rd` |

## Verification
A wrong cycle counter or a state that skips or stalls shows at the ports on the very operation it hits: the busy window is a cycle too long or too short, or `done` arrives early or twice. A mis-latched operand kind, bit index or operation appears in the same operation as a wrong `mem_sel`, a wrong `taken`, a wrong `next_pc`, or a stored byte that differs from the expected set-then-clear or decrement result. A write that is missing or spurious is visible in the memory contents within three cycles of the read. Sweeping every operation, operand kind and region with both polarities of every bit exposes each such fault within one operation.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [1:0] {
        OP_JSET    = 2'd0,
        OP_JCLR    = 2'd1,
        OP_JSETCLR = 2'd2,
        OP_DECJNZ  = 2'd3
    } br_op_e;

    typedef enum logic [2:0] {
        SRC_ACC         = 3'd0,
        SRC_FLAGS       = 3'd1,
        SRC_SHORT_BIT   = 3'd2,
        SRC_SPECIAL_BIT = 3'd3,
        SRC_HL_BIT      = 3'd4,
        SRC_REG_B       = 3'd5,
        SRC_REG_C       = 3'd6,
        SRC_SHORT_BYTE  = 3'd7
    } opnd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TEST,
        ST_STORE,
        ST_HOLD,
        ST_FINISH
    } st_e;

    function automatic logic is_byte_opnd(opnd_e s);
        return (s == SRC_REG_B) || (s == SRC_REG_C) || (s == SRC_SHORT_BYTE);
    endfunction

endpackage

// File: rtl/cbu_cycle_table.sv
module cbu_cycle_table
    import cbu_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LEN_W = 3
) (
    input  br_op_e             op,
    input  opnd_e              src,
    input  logic               fast_region,
    output logic               legal,
    output logic [CNT_W-1:0]   cycles,
    output logic [LEN_W-1:0]   len
);

    localparam logic [CNT_W-1:0] C2  = CNT_W'(2);
    localparam logic [CNT_W-1:0] C6  = CNT_W'(6);
    localparam logic [CNT_W-1:0] C8  = CNT_W'(8);
    localparam logic [CNT_W-1:0] C9  = CNT_W'(9);
    localparam logic [CNT_W-1:0] C10 = CNT_W'(10);
    localparam logic [CNT_W-1:0] C11 = CNT_W'(11);
    localparam logic [CNT_W-1:0] C12 = CNT_W'(12);

    logic is_dec;
    logic is_set;
    logic is_setclr;
    logic [CNT_W-1:0] slow_bit_cyc;
    logic [CNT_W-1:0] raw_cyc;
    logic [LEN_W-1:0] raw_len;

    assign is_dec    = (op == OP_DECJNZ);
    assign is_set    = (op == OP_JSET);
    assign is_setclr = (op == OP_JSETCLR);

    // count shared by memory-bit and flag forms outside fast RAM
    assign slow_bit_cyc = is_setclr ? C12 : C11;

    always_comb begin
        raw_cyc = C8;
        raw_len = LEN_W'(3);
        legal   = !is_dec;
        unique case (src)
            SRC_ACC: begin
                raw_cyc = C8;
                raw_len = LEN_W'(3);
            end
            SRC_FLAGS: begin
                raw_len = is_set ? LEN_W'(3) : LEN_W'(4);
                raw_cyc = is_set ? C9 : slow_bit_cyc;
            end
            SRC_SHORT_BIT: begin
                raw_len = is_set ? LEN_W'(3) : LEN_W'(4);
                if (fast_region)
                    raw_cyc = is_set ? C8 : C10;
                else
                    raw_cyc = is_set ? C9 : slow_bit_cyc;
            end
            SRC_SPECIAL_BIT: begin
                raw_len = LEN_W'(4);
                raw_cyc = slow_bit_cyc;
            end
            SRC_HL_BIT: begin
                raw_len = LEN_W'(3);
                raw_cyc = fast_region ? C10 : slow_bit_cyc;
            end
            SRC_REG_B, SRC_REG_C: begin
                legal   = is_dec;
                raw_len = LEN_W'(2);
                raw_cyc = C6;
            end
            SRC_SHORT_BYTE: begin
                legal   = is_dec;
                raw_len = LEN_W'(3);
                raw_cyc = fast_region ? C8 : C10;
            end
            default: begin
                legal   = 1'b0;
                raw_len = '0;
                raw_cyc = C2;
            end
        endcase
    end

    assign cycles = legal ? raw_cyc : C2;
    assign len    = legal ? raw_len : '0;

endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  br_op_e             op,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0]  opnd,
    output logic               take,
    output logic               wr_req,
    output logic [DATA_W-1:0]  wr_byte
);

    logic [DATA_W-1:0] cleared;
    logic [DATA_W-1:0] decremented;
    logic              tbit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_clr
        assign cleared[i] = (bit_idx == IDX_W'(i)) ? 1'b0 : opnd[i];
    end

    assign tbit        = opnd[bit_idx];
    assign decremented = opnd - DATA_W'(1);

    always_comb begin
        take    = 1'b0;
        wr_req  = 1'b0;
        wr_byte = opnd;
        unique case (op)
            OP_JSET: begin
                take = tbit;
            end
            OP_JCLR: begin
                take = !tbit;
            end
            OP_JSETCLR: begin
                take    = tbit;
                wr_req  = tbit;
                wr_byte = cleared;
            end
            OP_DECJNZ: begin
                take    = (decremented != '0);
                wr_req  = 1'b1;
                wr_byte = decremented;
            end
            default: begin
                take = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cbu_pc_calc.sv
module cbu_pc_calc #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 3,
    localparam int EXT_W = PC_W - DATA_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] disp,
    input  logic              take,
    output logic [PC_W-1:0]   npc
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] offset;

    assign seq_pc = pc + PC_W'(len);
    assign offset = take ? {{EXT_W{disp[DATA_W-1]}}, disp} : '0;
    assign npc    = seq_pc + offset;

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import cbu_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int LEN_W  = 3,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [2:0]        src,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              fast_region,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] disp,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [2:0]        mem_sel,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    st_e               state;
    st_e               state_nx;
    logic [CNT_W-1:0]  cnt;
    br_op_e            op_q;
    opnd_e             src_q;
    logic [IDX_W-1:0]  bit_q;
    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] disp_q;
    logic [LEN_W-1:0]  len_q;
    logic              legal_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              taken_q;
    logic [PC_W-1:0]   npc_q;

    logic              tab_legal;
    logic [CNT_W-1:0]  tab_cycles;
    logic [LEN_W-1:0]  tab_len;
    logic              ev_take;
    logic              ev_wr;
    logic [DATA_W-1:0] ev_byte;
    logic [PC_W-1:0]   calc_npc;
    logic              accept;
    logic              running;

    cbu_cycle_table #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_table (
        .op          (br_op_e'(op)),
        .src         (opnd_e'(src)),
        .fast_region (fast_region),
        .legal       (tab_legal),
        .cycles      (tab_cycles),
        .len         (tab_len)
    );

    cbu_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .op      (op_q),
        .bit_idx (bit_q),
        .opnd    (mem_rdata),
        .take    (ev_take),
        .wr_req  (ev_wr),
        .wr_byte (ev_byte)
    );

    cbu_pc_calc #(.PC_W(PC_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_pc (
        .pc   (pc_q),
        .len  (len_q),
        .disp (disp_q),
        .take (ev_take),
        .npc  (calc_npc)
    );

    assign running = (state == ST_FETCH) || (state == ST_TEST) ||
                     (state == ST_STORE) || (state == ST_HOLD);
    assign accept  = start && ((state == ST_IDLE) || (state == ST_FINISH));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                if (start)
                    state_nx = tab_legal ? ST_FETCH : ST_HOLD;
                else
                    state_nx = ST_IDLE;
            end
            ST_FETCH: state_nx = ST_TEST;
            ST_TEST:  state_nx = ST_STORE;
            ST_STORE: state_nx = (cnt == '0) ? ST_FINISH : ST_HOLD;
            ST_HOLD:  state_nx = (cnt == '0) ? ST_FINISH : ST_HOLD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // operation latch, cycle counter and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            op_q    <= OP_JSET;
            src_q   <= SRC_ACC;
            bit_q   <= '0;
            pc_q    <= '0;
            disp_q  <= '0;
            len_q   <= '0;
            legal_q <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            taken_q <= 1'b0;
            npc_q   <= '0;
        end else if (accept) begin
            cnt     <= tab_cycles - CNT_W'(1);
            op_q    <= br_op_e'(op);
            src_q   <= opnd_e'(src);
            bit_q   <= bit_idx;
            pc_q    <= pc_in;
            disp_q  <= disp;
            len_q   <= tab_len;
            legal_q <= tab_legal;
            wr_q    <= 1'b0;
            if (!tab_legal) begin
                taken_q <= 1'b0;
                npc_q   <= pc_in;
            end
        end else begin
            if (running && cnt != '0)
                cnt <= cnt - CNT_W'(1);
            if (state == ST_TEST) begin
                taken_q <= ev_take;
                npc_q   <= calc_npc;
                wr_q    <= ev_wr;
                wdata_q <= ev_byte;
            end
            if (state == ST_STORE)
                wr_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy      = running;
        done      = (state == ST_FINISH);
        mem_rd    = (state == ST_FETCH);
        mem_wr    = (state == ST_STORE) && wr_q;
        mem_sel   = src_q;
        mem_wdata = wdata_q;
        taken     = taken_q;
        next_pc   = npc_q;
    end

    // R10: a write lands two cycles after the read strobe
    assert_write_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R3: set-then-clear write removes only the tested bit and only on a taken branch
    assert_clear_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && op_q == OP_JSETCLR) |->
            (taken_q && mem_wdata == ($past(mem_rdata) & ~(DATA_W'(1) << bit_q))));

    // R3: plain bit tests never write
    assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (op_q == OP_JSETCLR || op_q == OP_DECJNZ));

    // R4: decrement stores the read byte minus one
    assert_dec_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && op_q == OP_DECJNZ) |-> (mem_wdata == DATA_W'($past(mem_rdata) - 1'b1)));

    // R9: done is a single cycle, follows busy, and never overlaps it
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_busy_done_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R11: illegal pairings touch nothing
    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !legal_q) |-> (!mem_rd && !mem_wr));

    // R10: the read strobe starts a busy window
    assert_read_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && legal_q |-> mem_rd);

endmodule

// File: tb/cond_branch_unit_test.sv
module cond_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op_i;
    logic [2:0]  src_i;
    logic [2:0]  bit_i;
    logic        fast_i;
    logic [15:0] pc_i;
    logic [7:0]  disp_i;
    logic        busy;
    logic        done;
    logic        taken;
    logic [15:0] next_pc;
    logic        mem_rd;
    logic        mem_wr;
    logic [2:0]  mem_sel;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem [8];

    int tests = 0;
    int fails = 0;
    int run_no = 0;

    always #5 clk = ~clk;

    cond_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .src(src_i),
        .bit_idx(bit_i), .fast_region(fast_i), .pc_in(pc_i), .disp(disp_i),
        .busy(busy), .done(done), .taken(taken), .next_pc(next_pc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_sel(mem_sel),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // operand store: one-cycle read latency, write on strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_sel];
        if (mem_wr) mem[mem_sel] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s (run %0d): actual %0h expected %0h", req, what, run_no, act, exp);
        end
    endtask

    function automatic bit exp_legal(int op, int src);
        return (op == 3) == (src >= 5);
    endfunction

    function automatic int exp_len(int op, int src);
        if (!exp_legal(op, src)) return 0;
        case (src)
            0, 4:    return 3;
            3:       return 4;
            1, 2:    return (op == 0) ? 3 : 4;
            5, 6:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int exp_cyc(int op, int src, bit fast);
        if (!exp_legal(op, src)) return 2;
        case (src)
            0: return 8;
            1: return (op == 0) ? 9 : (op == 1) ? 11 : 12;
            2: if (fast) return (op == 0) ? 8 : 10;
               else return (op == 0) ? 9 : (op == 1) ? 11 : 12;
            3: return (op == 2) ? 12 : 11;
            4: if (fast) return 10;
               else return (op == 2) ? 12 : 11;
            5, 6: return 6;
            default: return fast ? 8 : 10;
        endcase
    endfunction

    function automatic string cyc_tag(int src, bit fast);
        if (src == 0 || src == 1 || src == 3 || src == 5 || src == 6) return "R8";
        return fast ? "R6" : "R7";
    endfunction

    task automatic run_op(input int op, input int src, input int b, input bit fast,
                          input logic [15:0] pc, input logic [7:0] d,
                          input logic [7:0] data, input bit poke);
        int nbusy = 0;
        int nrd = 0;
        int nwr = 0;
        int rd_at = -1;
        int wr_at = -1;
        int guard = 0;
        bit lg;
        bit tk;
        logic [7:0] nd;
        logic [15:0] npc;
        int len;
        int cyc;
        string rq;

        run_no++;
        lg  = exp_legal(op, src);
        len = exp_len(op, src);
        cyc = exp_cyc(op, src, fast);
        nd  = data;
        tk  = 1'b0;
        if (lg) begin
            case (op)
                0: tk = data[b];
                1: tk = !data[b];
                2: begin tk = data[b]; if (tk) nd = data & ~(8'd1 << b); end
                default: begin nd = data - 8'd1; tk = (nd != 8'd0); end
            endcase
        end
        npc = lg ? (pc + 16'(len) + (tk ? {{8{d[7]}}, d} : 16'd0)) : pc;

        for (int k = 0; k < 8; k++) mem[k] = 8'h3C ^ 8'(k);
        mem[src] = data;

        @(negedge clk);
        op_i = 2'(op); src_i = 3'(src); bit_i = 3'(b); fast_i = fast;
        pc_i = pc; disp_i = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 40) begin
            if (busy) nbusy++;
            if (mem_rd) begin nrd++; rd_at = guard; end
            if (mem_wr) begin nwr++; wr_at = guard; end
            if (poke && guard == 1) begin
                // R9: a second start while busy must be ignored
                start = 1'b1; op_i = 2'd3; src_i = 3'd5; pc_i = 16'h1234; disp_i = 8'h10;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;

        chk(guard < 40, "R9", "done reached", guard, 0);
        chk(nbusy == cyc, cyc_tag(src, fast), "busy cycles", nbusy, cyc);
        chk(!busy, "R9", "busy low at done", busy, 0);
        chk(taken == tk, lg ? ((op == 3) ? "R4" : "R2") : "R11", "taken", taken, tk);
        chk(next_pc == npc, lg ? "R1/R5" : "R11", "next_pc", next_pc, npc);
        chk(nrd == (lg ? 1 : 0), lg ? "R10" : "R11", "read count", nrd, lg ? 1 : 0);
        if (lg) chk(rd_at == 0, "R10", "read slot", rd_at, 0);
        chk(nwr == ((nd != data || op == 3) && lg ? 1 : 0), (op == 3) ? "R4" : "R3",
            "write count", nwr, (nd != data || op == 3) && lg ? 1 : 0);
        if (nwr == 1) chk(wr_at == 2, "R10", "write slot", wr_at, 2);
        chk(mem[src] == nd, (op == 3) ? "R4" : "R3", "stored byte", mem[src], nd);
        @(negedge clk);
        chk(!done, "R9", "done one cycle", done, 0);
    endtask

    function automatic logic [7:0] dec_data(int idx);
        case (idx)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h02;
            3: return 8'h80;
            default: return 8'(idx * 37);
        endcase
    endfunction

    initial begin
        #1_500_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] dsel [5];
        dsel[0] = 8'h7F; dsel[1] = 8'h80; dsel[2] = 8'h00; dsel[3] = 8'hFE; dsel[4] = 8'h05;
        rst_n = 1'b0; start = 1'b0; op_i = '0; src_i = '0; bit_i = '0; fast_i = 1'b0;
        pc_i = '0; disp_i = '0; mem_rdata = '0;
        for (int k = 0; k < 8; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy && !done, "R12", "busy/done", {busy, done}, 0);
        chk(!mem_rd && !mem_wr, "R12", "strobes", {mem_rd, mem_wr}, 0);
        chk(!taken && next_pc == 16'd0, "R12", "result", next_pc, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // near-exhaustive sweep over op, kind, region, bit and bit polarity
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 8; s++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int b = 0; b < 8; b++) begin
                        for (int v = 0; v < 2; v++) begin
                            logic [7:0] dat;
                            logic [15:0] pcv;
                            if (o == 3) dat = dec_data(b * 2 + v);
                            else dat = v ? (8'hA5 | (8'd1 << b)) : (8'hA5 & ~(8'd1 << b));
                            pcv = 16'hFFF0 + 16'((o * 8 + s) * 515 + b * 3 + v);
                            run_op(o, s, b, f[0], pcv, dsel[(run_no) % 5], dat, 1'b0);
                        end
                    end
                end
            end
        end

        // R1: explicit wrap in both directions
        run_op(0, 0, 2, 1'b1, 16'hFFFE, 8'h05, 8'h04, 1'b0);
        run_op(1, 4, 7, 1'b0, 16'h0001, 8'hF0, 8'h00, 1'b0);
        // R9: start while busy is ignored
        run_op(2, 2, 5, 1'b0, 16'h4000, 8'h22, 8'hFF, 1'b1);
        run_op(3, 7, 0, 1'b1, 16'h8000, 8'h81, 8'h01, 1'b1);
        // R11: illegal pairings
        run_op(3, 0, 0, 1'b1, 16'hABCD, 8'h10, 8'h05, 1'b0);
        run_op(0, 5, 3, 1'b0, 16'h1357, 8'h7F, 8'h08, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule